// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a parameterized set of maskable sources and one non-maskable line, and turns them into a single request to a processor. Each maskable source has its own 3-bit priority level. Software writes these levels through a small write port. A source whose level is 0 or 7 is switched off. Every request line is edge-captured into a pending flag. The block compares the pending flags with the processor's current 3-bit mask and presents the strongest qualifying request, together with its level.

When the processor acknowledges, the block latches the vector of the winning source. Maskable source `i` gets vector `0x10 + 4*i`, so each vector selects a 4-byte table entry. The non-maskable line gets vector `0x08`. The same acknowledge edge clears the winner's pending flag. The latched vector stays on its port until the next accepted acknowledge.

The non-maskable line is always presented at level 7 and ignores every level setting. A fresh edge on it is taken even while an earlier non-maskable request is being serviced.

Top module: `irq_arbiter`

## Requirements
- R1: A maskable source whose level is 0 or 7 never raises the request. Its rising edges are not captured, and any flag it already had pending is dropped, so re-enabling it later raises nothing until a new edge arrives.
- R2: A pending maskable source qualifies only when its level is greater than or equal to `cpu_mask`. When `irq_valid` is high, `irq_level >= cpu_mask`.
- R3: `irq_valid` is high whenever any source qualifies. `irq_level` then carries the highest qualifying level. `irq_level` is 0 while `irq_valid` is low.
- R4: Among qualifying sources that share the highest level, the one with the lowest index wins, which is the one with the smallest vector.
- R5: A clock edge with `ack` and `irq_valid` both high loads `vec` with the winner's vector and clears the winner's pending flag. The vector is `0x10 + 4*index` for a maskable source and `0x08` for the non-maskable line. `vec` holds its value until the next such edge.
- R6: A pending non-maskable request always produces `irq_valid` with `irq_level = 7`, whatever the mask is. It wins over every maskable source.
- R7: A new rising edge of `nmi_req` after its previous acknowledge raises a new non-maskable request. This holds while the mask is 7.
- R8: Pending flags are set only by a rising edge of the request line. A line held high yields exactly one request.
- R9: If a source's request line rises in the same cycle in which that source is acknowledged, the new edge wins and the source stays pending.
- R10: An `ack` while `irq_valid` is low changes neither `vec` nor any pending flag.
- R11: After synchronous reset, all levels are 0, nothing is pending, `irq_valid` is 0, `irq_level` is 0 and `vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Maskable request lines, edge-captured |
| nmi_req | input | 1 | Non-maskable request line, edge-captured |
| cfg_we | input | 1 | Level register write strobe |
| cfg_idx | input | $clog2(NUM_SRC) | Source index for the level write |
| cfg_level | input | 3 | Level value to write |
| cpu_mask | input | 3 | Processor's current interrupt mask |
| irq_valid | output | 1 | Request to the processor |
| irq_level | output | 3 | Level of the presented request |
| ack | input | 1 | Processor acknowledge / vector read |
| vec | output | 8 | Vector latched at the last accepted acknowledge |

## Verification
Two events can land on the same clock edge for one source. The acknowledge clears that source's pending flag, and a fresh rising edge on its request line sets the flag again. The bench provokes this by raising the line of an already pending source in exactly the cycle in which it drives `ack`. It then judges the outcome at the ports: the correct vector must appear, and the source must remain presented at its level. A second acknowledge must then retire it. A second overlap is also covered: a level write that disables a source while that source is pending, with the flag then proven dropped after the source is re-enabled.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_SRC_DEF = 8;
    localparam int LVL_W       = 3;
    localparam int VEC_W       = 8;
    localparam int WIN_IDX_W   = 8;

    typedef logic [LVL_W-1:0] level_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam level_t LVL_NMI      = '1;
    localparam vec_t   NMI_VEC      = 8'h08;
    localparam vec_t   SRC_VEC_BASE = 8'h10;

    typedef struct packed {
        logic                 valid;
        logic                 is_nmi;
        logic [WIN_IDX_W-1:0] idx;
        level_t               level;
    } win_t;

    function automatic logic lvl_enabled(level_t l);
        return (l != '0) && (l != '1);
    endfunction

    function automatic vec_t src_vector(logic [WIN_IDX_W-1:0] idx);
        return SRC_VEC_BASE + vec_t'({idx, 2'b00});
    endfunction

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_arb_pkg::*;
#(
    parameter int NSRC = NUM_SRC_DEF,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IW-1:0]              widx,
    input  level_t                     wlevel,
    output logic [NSRC-1:0][LVL_W-1:0] levels
);

    for (genvar g = 0; g < NSRC; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                levels[g] <= '0;
            end else if (we && widx == IW'(g)) begin
                levels[g] <= wlevel;
            end
        end
    end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
    import irq_arb_pkg::*;
#(
    parameter int NSRC = NUM_SRC_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic            nmi_req,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] clr_src,
    input  logic            clr_nmi,
    output logic [NSRC-1:0] pend,
    output logic            nmi_pend
);

    logic [NSRC-1:0] req_q;
    logic            nmi_q;
    logic [NSRC-1:0] rise;
    logic            nmi_rise;

    assign rise     = req & ~req_q;
    assign nmi_rise = nmi_req & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            req_q <= req;
            nmi_q <= nmi_req;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)            pend[g] <= 1'b0;
            else if (!en[g])    pend[g] <= 1'b0;
            else if (rise[g])   pend[g] <= 1'b1;
            else if (clr_src[g]) pend[g] <= 1'b0;
        end

        // R5: an acknowledged source with no new edge is no longer pending
        a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (clr_src[g] && !rise[g]) |=> !pend[g]);
        // R9: a new edge on an enabled source survives its own acknowledge
        a_r9_edge_wins: assert property (@(posedge clk) disable iff (rst)
            (en[g] && rise[g]) |=> pend[g]);
    end

    always_ff @(posedge clk) begin
        if (rst)           nmi_pend <= 1'b0;
        else if (nmi_rise) nmi_pend <= 1'b1;
        else if (clr_nmi)  nmi_pend <= 1'b0;
    end

    // R7: a fresh non-maskable edge is always captured
    a_r7_nmi_capture: assert property (@(posedge clk) disable iff (rst)
        nmi_rise |=> nmi_pend);

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int NSRC = NUM_SRC_DEF
) (
    input  logic [NSRC-1:0]            pend,
    input  logic                       nmi_pend,
    input  logic [NSRC-1:0][LVL_W-1:0] levels,
    input  level_t                     mask,
    output win_t                       win
);

    logic                 found;
    level_t               best_lvl;
    logic [WIN_IDX_W-1:0] best_idx;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        // ascending scan with strict compare: lowest index keeps a tie
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && lvl_enabled(levels[i]) && levels[i] >= mask &&
                (!found || levels[i] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = levels[i];
                best_idx = WIN_IDX_W'(i);
            end
        end
        win.valid  = found || nmi_pend;
        win.is_nmi = nmi_pend;
        win.idx    = nmi_pend ? '0 : best_idx;
        win.level  = nmi_pend ? LVL_NMI : best_lvl;
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               nmi_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [2:0]         cpu_mask,
    input  logic [2:0]         cfg_level,
    output logic               irq_valid,
    output logic [2:0]         irq_level,
    input  logic               ack,
    output logic [7:0]         vec
);

    logic [NUM_SRC-1:0][LVL_W-1:0] levels;
    logic [NUM_SRC-1:0]            en;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            clr_src;
    logic                          nmi_pend;
    logic                          clr_nmi;
    logic                          fire;
    win_t                          win;

    irq_level_regs #(.NSRC(NUM_SRC)) u_levels (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .widx   (cfg_idx),
        .wlevel (cfg_level),
        .levels (levels)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
        assign en[g]      = lvl_enabled(levels[g]);
        assign clr_src[g] = fire && !win.is_nmi && (win.idx == WIN_IDX_W'(g));
    end

    irq_pending_bank #(.NSRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req      (src_req),
        .nmi_req  (nmi_req),
        .en       (en),
        .clr_src  (clr_src),
        .clr_nmi  (clr_nmi),
        .pend     (pend),
        .nmi_pend (nmi_pend)
    );

    irq_select #(.NSRC(NUM_SRC)) u_sel (
        .pend     (pend),
        .nmi_pend (nmi_pend),
        .levels   (levels),
        .mask     (cpu_mask),
        .win      (win)
    );

    assign fire      = ack && win.valid;
    assign clr_nmi   = fire && win.is_nmi;
    assign irq_valid = win.valid;
    assign irq_level = win.valid ? win.level : '0;

    always_ff @(posedge clk) begin
        if (rst)       vec <= '0;
        else if (fire) vec <= win.is_nmi ? NMI_VEC : src_vector(win.idx);
    end

    // R2: a presented request never sits below the mask
    a_r2_mask_ok: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level >= cpu_mask));
    // R6: a pending non-maskable request is presented at the top level
    a_r6_nmi_top: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (irq_valid && irq_level == LVL_NMI));
    // R1: a winning maskable source always has an enabling level
    a_r1_winner_enabled: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !win.is_nmi) |-> lvl_enabled(levels[win.idx[IDX_W-1:0]]));
    // R10: without an accepted acknowledge the vector holds
    a_r10_vec_hold: assert property (@(posedge clk) disable iff (rst)
        !(ack && irq_valid) |=> $stable(vec));
    // R5: a maskable vector is 4-byte aligned and above the base
    a_r5_vec_shape: assert property (@(posedge clk) disable iff (rst)
        (fire && !win.is_nmi) |=> (vec[1:0] == 2'b00 && vec >= SRC_VEC_BASE));
    // R3: the level output is 0 whenever nothing is requested
    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_level == '0));

endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_req = '0;
    logic          nmi_req = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [2:0]    cfg_level = '0;
    logic [2:0]    cpu_mask = '0;
    logic          irq_valid;
    logic [2:0]    irq_level;
    logic          ack = 1'b0;
    logic [7:0]    vec;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_arbiter #(.NUM_SRC(NS)) i_irq_arbiter (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .nmi_req   (nmi_req),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cpu_mask  (cpu_mask),
        .cfg_level (cfg_level),
        .irq_valid (irq_valid),
        .irq_level (irq_level),
        .ack       (ack),
        .vec       (vec)
    );

    function automatic logic [7:0] sv(int i);
        return 8'h10 + 8'(i * 4);
    endfunction

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic expect_req(input string rq, input logic v, input logic [2:0] l);
        #1;
        chk(irq_valid == v, {rq, " irq_valid"}, int'(irq_valid), int'(v));
        chk(irq_level == l, {rq, " irq_level"}, int'(irq_level), int'(l));
    endtask

    task automatic expect_vec(input string rq, input logic [7:0] v);
        #1;
        chk(vec == v, {rq, " vec"}, int'(vec), int'(v));
    endtask

    task automatic set_level(input int i, input logic [2:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_level = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk);
        src_req = src_req | m;
        @(negedge clk);
        src_req = src_req & ~m;
    endtask

    task automatic pulse_nmi();
        @(negedge clk);
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        expect_req("R11", 1'b0, 3'd0);
        expect_vec("R11", 8'h00);
    endtask

    task automatic t_basic();
        set_level(3, 3'd4);
        pulse(8'h08);
        expect_req("R3", 1'b1, 3'd4);
        do_ack();
        expect_vec("R5", sv(3));
        expect_req("R5", 1'b0, 3'd0);
    endtask

    task automatic t_mask();
        set_level(2, 3'd3);
        cpu_mask = 3'd4;
        pulse(8'h04);
        expect_req("R2 below", 1'b0, 3'd0);
        cpu_mask = 3'd3;
        expect_req("R2 equal", 1'b1, 3'd3);
        do_ack();
        expect_vec("R2", sv(2));
        cpu_mask = 3'd0;
    endtask

    task automatic t_disabled();
        pulse(8'h20);
        expect_req("R1 level0", 1'b0, 3'd0);
        set_level(5, 3'd7);
        pulse(8'h20);
        expect_req("R1 level7", 1'b0, 3'd0);
        set_level(5, 3'd5);
        expect_req("R1 not captured", 1'b0, 3'd0);
        pulse(8'h20);
        expect_req("R1 enabled", 1'b1, 3'd5);
        do_ack();
        expect_vec("R1", sv(5));
    endtask

    task automatic t_drop();
        set_level(1, 3'd2);
        pulse(8'h02);
        expect_req("R1 pre", 1'b1, 3'd2);
        set_level(1, 3'd0);
        expect_req("R1 off", 1'b0, 3'd0);
        set_level(1, 3'd2);
        expect_req("R1 dropped", 1'b0, 3'd0);
    endtask

    task automatic t_tie();
        set_level(4, 3'd5);
        set_level(6, 3'd5);
        pulse(8'h50);
        expect_req("R4", 1'b1, 3'd5);
        do_ack();
        expect_vec("R4 first", sv(4));
        do_ack();
        expect_vec("R4 second", sv(6));
        expect_req("R4 empty", 1'b0, 3'd0);
    endtask

    task automatic t_prio();
        set_level(0, 3'd1);
        set_level(7, 3'd6);
        pulse(8'h81);
        expect_req("R3 high", 1'b1, 3'd6);
        do_ack();
        expect_vec("R3 high", sv(7));
        expect_req("R3 low", 1'b1, 3'd1);
        do_ack();
        expect_vec("R3 low", sv(0));
    endtask

    task automatic t_nmi();
        cpu_mask = 3'd7;
        pulse(8'h80);
        expect_req("R2 mask7", 1'b0, 3'd0);
        pulse_nmi();
        expect_req("R6", 1'b1, 3'd7);
        do_ack();
        expect_vec("R6", 8'h08);
        expect_req("R6 done", 1'b0, 3'd0);
        pulse_nmi();
        expect_req("R7", 1'b1, 3'd7);
        do_ack();
        expect_vec("R7", 8'h08);
        cpu_mask = 3'd0;
        expect_req("R2 unmask", 1'b1, 3'd6);
        pulse_nmi();
        expect_req("R6 beats", 1'b1, 3'd7);
        do_ack();
        expect_vec("R6 beats", 8'h08);
        do_ack();
        expect_vec("R6 after", sv(7));
    endtask

    task automatic t_held();
        @(negedge clk);
        src_req[3] = 1'b1;
        @(negedge clk);
        expect_req("R8 edge", 1'b1, 3'd4);
        do_ack();
        expect_vec("R8", sv(3));
        repeat (3) @(negedge clk);
        expect_req("R8 held", 1'b0, 3'd0);
        src_req[3] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ack_edge();
        pulse(8'h08);
        @(negedge clk);
        ack = 1'b1; src_req[3] = 1'b1;
        @(negedge clk);
        ack = 1'b0; src_req[3] = 1'b0;
        expect_vec("R9", sv(3));
        expect_req("R9 kept", 1'b1, 3'd4);
        do_ack();
        expect_req("R9 retired", 1'b0, 3'd0);
    endtask

    task automatic t_idle_ack();
        do_ack();
        expect_vec("R10", sv(3));
        expect_req("R10", 1'b0, 3'd0);
        set_level(2, 3'd3);
        pulse(8'h04);
        expect_req("R10 later", 1'b1, 3'd3);
        do_ack();
        expect_vec("R10 later", sv(2));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_mask();
        t_disabled();
        t_drop();
        t_tie();
        t_prio();
        t_nmi();
        t_held();
        t_ack_edge();
        t_idle_ack();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule